// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the pin configuration for several GPIO ports of up to 32 pins each and turns it into pad controls. Each pin has a function select, a latched output bit, a drive-strength code and a pull-bias code. From these the block drives, for every pin, an output enable, an output value, pull-up and pull-down requests and a 2-bit drive code. Software reaches the state through a plain 32-bit bus with a word address, a write strobe and a registered read word.

Each port owns a fixed window of nine 32-bit words (0x24 bytes), and port n starts at word 9n. Inside a window, the function selects come first, then the data word, then the drive words, then the pull words. Software changes one pin with a read-modify-write, so every field reads back exactly as it was written. Reading the data word returns the synchronised pad level for pins set up as inputs. For all other pins it returns the latched output bit.

Top module: `gpio_bank`

## Requirements
- R1: Port n occupies word addresses 9n to 9n+8. Offsets 0-3 hold function selects, offset 4 holds data, offsets 5-6 hold drive codes and offsets 7-8 hold pull codes. An address at or above 9*NUM_PORTS reads as zero, and a write to such an address changes no state.
- R2: Pin p has a 4-bit function field in word p/8 at bits 4*(p%8)+3..4*(p%8). All four bits read back exactly as written.
- R3: Pin p has a 2-bit drive field in word 5+p/16 at bits 2*(p%16)+1..2*(p%16). It reads back exactly as written and appears on the pin's slice of pad_drv.
- R4: Pin p has a 2-bit pull field in word 7+p/16 at bits 2*(p%16)+1..2*(p%16). It reads back exactly as written. Code 1 raises pad_pu, code 2 raises pad_pd, and codes 0 and 3 raise neither. pad_pu and pad_pd are never high together on a pin.
- R5: Only the low 3 bits of a function field act on the pad. Code 0 gives an input with pad_oe low. Code 1 gives an output with pad_oe high and pad_out equal to the pin's data bit. Any other code holds pad_oe and pad_out low. Bit 3 of the field has no effect on the pad.
- R6: A write to the data word stores bit p as pin p's latched bit, whatever the pin's function. A read of the data word returns the synchronised pad input at bit p for pins with function code 0, and the latched bit for all other pins.
- R7: A pad input passes through two flops before it reaches the read path. A level presented before rising edge k appears on bus_rdata after edge k+2 and not earlier.
- R8: After reset, every function field and data bit is 0, every pull code is 0 and every drive code is 1. The pads show pad_oe, pad_out, pad_pu and pad_pd all low, and pad_drv equal to 01 on every pin.
- R9: bus_rdata is registered and shows the word selected by the address present at the previous rising edge. The pad outputs change on the rising edge after the edge that performed the write.
- R10: A write changes only the fields of the addressed word. The other words of the same port and all words of other ports keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PORTS*PINS | Asynchronous pad input levels, port-major |
| pad_oe | output | NUM_PORTS*PINS | Pad output enables |
| pad_out | output | NUM_PORTS*PINS | Pad output values |
| pad_pu | output | NUM_PORTS*PINS | Pull-up requests |
| pad_pd | output | NUM_PORTS*PINS | Pull-down requests |
| pad_drv | output | 2*NUM_PORTS*PINS | Drive code, 2 bits per pin |

## Verification
A field stored at the wrong bit, or decoded for the wrong port, shows up on the next read of that word. It also shows on the matching pad slice one edge after the write. A full readback after every round of writes therefore catches a misplaced field within a few cycles. A wrong function decode or pull decode shows on pad_oe, pad_out, pad_pu or pad_pd as soon as the pad registers update, which is one edge after the write. A synchroniser that is too short or too long shows as the new pad level appearing on a data-word read one cycle early or late.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WIN_WORDS = 9;
  localparam int OFF_FN    = 0;
  localparam int OFF_DAT   = 4;
  localparam int OFF_DRV   = 5;
  localparam int OFF_PUL   = 7;

  localparam logic [2:0] FN_INPUT  = 3'd0;
  localparam logic [2:0] FN_OUTPUT = 3'd1;

  localparam logic [1:0] PULL_UP   = 2'd1;
  localparam logic [1:0] PULL_DOWN = 2'd2;
  localparam logic [1:0] DRV_RESET = 2'd1;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8,
  parameter int BASE   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [PINS-1:0]       pin_in,
  output logic [31:0]           rd_word,
  output logic [PINS-1:0][2:0]  fn_code,
  output logic [PINS-1:0]       dat_bit,
  output logic [PINS-1:0][1:0]  drv_code,
  output logic [PINS-1:0][1:0]  pul_code
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE + WIN_WORDS);

  logic [PINS-1:0][3:0] fn_q;
  logic [PINS-1:0]      dat_q;
  logic [PINS-1:0][1:0] drv_q;
  logic [PINS-1:0][1:0] pul_q;
  logic [ADDR_W-1:0]    off;
  logic                 hit;

  assign hit = (addr >= BASE_A) && (addr < END_A);
  assign off = addr - BASE_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PINS; p++) begin
        fn_q[p]  <= '0;
        dat_q[p] <= 1'b0;
        drv_q[p] <= DRV_RESET;
        pul_q[p] <= '0;
      end
    end else if (wr_en && hit) begin
      for (int p = 0; p < PINS; p++) begin
        if (int'(off) == OFF_FN + p / 8)   fn_q[p]  <= wdata[4*(p%8) +: 4];
        if (int'(off) == OFF_DAT)          dat_q[p] <= wdata[p];
        if (int'(off) == OFF_DRV + p / 16) drv_q[p] <= wdata[2*(p%16) +: 2];
        if (int'(off) == OFF_PUL + p / 16) pul_q[p] <= wdata[2*(p%16) +: 2];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      for (int p = 0; p < PINS; p++) begin
        if (int'(off) == OFF_FN + p / 8)   rd_word[4*(p%8) +: 4]  = fn_q[p];
        if (int'(off) == OFF_DAT)
          rd_word[p] = (fn_q[p][2:0] == FN_INPUT) ? pin_in[p] : dat_q[p];
        if (int'(off) == OFF_DRV + p / 16) rd_word[2*(p%16) +: 2] = drv_q[p];
        if (int'(off) == OFF_PUL + p / 16) rd_word[2*(p%16) +: 2] = pul_q[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < PINS; p++) fn_code[p] = fn_q[p][2:0];
  end
  assign dat_bit  = dat_q;
  assign drv_code = drv_q;
  assign pul_code = pul_q;

  // R6: a data-word write lands in the latched bits on the next edge
  assert_data_store_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && int'(off) == OFF_DAT) |=> (dat_q == $past(wdata[PINS-1:0])));

  // R10: no write to this window leaves all of its state unchanged
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit) |=> ($stable(fn_q) && $stable(dat_q) && $stable(drv_q) && $stable(pul_q)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PINS-1:0][2:0] fn_code,
  input  logic [PINS-1:0]      dat_bit,
  input  logic [PINS-1:0][1:0] drv_code,
  input  logic [PINS-1:0][1:0] pul_code,
  output logic [PINS-1:0]      oe_q,
  output logic [PINS-1:0]      out_q,
  output logic [PINS-1:0]      pu_q,
  output logic [PINS-1:0]      pd_q,
  output logic [PINS-1:0][1:0] drv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      out_q <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      for (int p = 0; p < PINS; p++) drv_q[p] <= DRV_RESET;
    end else begin
      for (int p = 0; p < PINS; p++) begin
        oe_q[p]  <= (fn_code[p] == FN_OUTPUT);
        out_q[p] <= (fn_code[p] == FN_OUTPUT) && dat_bit[p];
        pu_q[p]  <= (pul_code[p] == PULL_UP);
        pd_q[p]  <= (pul_code[p] == PULL_DOWN);
        drv_q[p] <= drv_code[p];
      end
    end
  end

  // R5: a pin that is not driving never shows a high output value
  assert_out_gated_R5: assert property (@(posedge clk) disable iff (rst)
    ((out_q & ~oe_q) == '0));

  // R4: pull-up and pull-down never requested together on a pin
  assert_pull_excl_R4: assert property (@(posedge clk) disable iff (rst)
    ((pu_q & pd_q) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PINS      = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PORTS*PINS-1:0]   pad_in,
  output logic [NUM_PORTS*PINS-1:0]   pad_oe,
  output logic [NUM_PORTS*PINS-1:0]   pad_out,
  output logic [NUM_PORTS*PINS-1:0]   pad_pu,
  output logic [NUM_PORTS*PINS-1:0]   pad_pd,
  output logic [2*NUM_PORTS*PINS-1:0] pad_drv
);
  localparam int TOTAL_WORDS = NUM_PORTS * WIN_WORDS;
  localparam int ALL_PINS    = NUM_PORTS * PINS;

  logic [ALL_PINS-1:0] pin_sync;
  logic [31:0]         port_rd [NUM_PORTS];
  logic [31:0]         rd_any;

  gpio_in_sync #(.W(ALL_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic [PINS-1:0][2:0] fn_code;
    logic [PINS-1:0]      dat_bit;
    logic [PINS-1:0][1:0] drv_code;
    logic [PINS-1:0][1:0] pul_code;
    logic [PINS-1:0][1:0] drv_pad;

    gpio_port_regs #(.PINS(PINS), .ADDR_W(ADDR_W), .BASE(g * WIN_WORDS)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pin_in   (pin_sync[g*PINS +: PINS]),
      .rd_word  (port_rd[g]),
      .fn_code  (fn_code),
      .dat_bit  (dat_bit),
      .drv_code (drv_code),
      .pul_code (pul_code)
    );

    gpio_pad_drive #(.PINS(PINS)) u_pad (
      .clk      (clk),
      .rst      (rst),
      .fn_code  (fn_code),
      .dat_bit  (dat_bit),
      .drv_code (drv_code),
      .pul_code (pul_code),
      .oe_q     (pad_oe[g*PINS +: PINS]),
      .out_q    (pad_out[g*PINS +: PINS]),
      .pu_q     (pad_pu[g*PINS +: PINS]),
      .pd_q     (pad_pd[g*PINS +: PINS]),
      .drv_q    (drv_pad)
    );

    assign pad_drv[g*2*PINS +: 2*PINS] = drv_pad;
  end

  always_comb begin
    rd_any = '0;
    for (int g = 0; g < NUM_PORTS; g++) rd_any = rd_any | port_rd[g];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_any;
  end

  // R1: addresses past the last window read as zero
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= ADDR_W'(TOTAL_WORDS)) |=> (bus_rdata == '0));

  // R8: the first cycle out of reset shows drive code 1 on every pin
  assert_reset_drive_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_drv == {ALL_PINS{DRV_RESET}}));
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int NP = 2;
  localparam int PN = 32;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP*PN-1:0]  pad_in = '0;
  logic [NP*PN-1:0]  pad_oe, pad_out, pad_pu, pad_pd;
  logic [2*NP*PN-1:0] pad_drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] img [NP][9];

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .PINS(PN), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_drv(pad_drv)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < NP * 9) img[a/9][a%9] = d;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_word(input int pr, input int w);
    logic [31:0] r;
    if (w != 4) return img[pr][w];
    for (int p = 0; p < PN; p++) begin
      if (((img[pr][p/8] >> (4*(p%8))) & 32'h7) == 0) r[p] = pad_in[pr*PN+p];
      else r[p] = img[pr][4][p];
    end
    return r;
  endfunction

  task automatic check_all_words(input string req);
    logic [31:0] d;
    for (int pr = 0; pr < NP; pr++)
      for (int w = 0; w < 9; w++) begin
        bus_read(pr*9 + w, d);
        check(req, {32'd0, d}, {32'd0, exp_word(pr, w)});
      end
  endtask

  task automatic check_pads(input string req);
    for (int pr = 0; pr < NP; pr++) begin
      logic [PN-1:0] e_oe, e_out, e_pu, e_pd;
      logic [2*PN-1:0] e_drv;
      for (int p = 0; p < PN; p++) begin
        int code, pl;
        code = int'((img[pr][p/8] >> (4*(p%8))) & 32'h7);
        pl   = int'((img[pr][7+p/16] >> (2*(p%16))) & 32'h3);
        e_oe[p]  = (code == 1);
        e_out[p] = (code == 1) && img[pr][4][p];
        e_pu[p]  = (pl == 1);
        e_pd[p]  = (pl == 2);
        e_drv[2*p +: 2] = 2'((img[pr][5+p/16] >> (2*(p%16))) & 32'h3);
      end
      check({req, " R5 oe"},  {32'd0, pad_oe[pr*PN +: PN]},  {32'd0, e_oe});
      check({req, " R5 out"}, {32'd0, pad_out[pr*PN +: PN]}, {32'd0, e_out});
      check({req, " R4 pu"},  {32'd0, pad_pu[pr*PN +: PN]},  {32'd0, e_pu});
      check({req, " R4 pd"},  {32'd0, pad_pd[pr*PN +: PN]},  {32'd0, e_pd});
      check({req, " R3 drv"}, pad_drv[pr*2*PN +: 2*PN], e_drv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int pr = 0; pr < NP; pr++)
      for (int w = 0; w < 9; w++)
        img[pr][w] = (w == 5 || w == 6) ? 32'h5555_5555 : 32'h0;
    pad_in = 64'hA5C3_0F96_3C5A_E187;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8 reset state at the pads and in every word (R6 data reads pad inputs)
    check_pads("R8 reset");
    repeat (4) @(negedge clk);
    check_all_words("R8 reset readback");

    // R2 R3 R4 R5 R6: sweep of patterns over every word of every port
    for (int it = 0; it < 4; it++) begin
      pad_in = {32'h9E37_79B9 * (it + 3), 32'h7F4A_7C15 * (it + 5)};
      for (int pr = 0; pr < NP; pr++)
        for (int w = 0; w < 9; w++)
          bus_write(pr*9 + w, (32'h9E37_79B9 * 32'(it*32 + pr*9 + w + 1)) ^ 32'h1357_2468);
      repeat (4) @(negedge clk);
      check_all_words("R2 R3 R4 R6 sweep readback");
      check_pads("R5 sweep pads");
    end

    // R5: bit 3 of the function field has no pad effect
    bus_write(0, 32'h9898_9898);
    bus_write(4, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R5 bit3 ignored oe", {32'd0, pad_oe[31:0]}, {32'd0, 32'h0000_FF00 & 32'hFFFF_FFFF & ((img[0][1] & 32'h0) | 32'h0) | exp_oe0()});
    check_pads("R5 bit3");

    // R1: unmapped writes change nothing, unmapped reads return zero
    bus_write(NP*9, 32'hFFFF_FFFF);
    bus_write(255, 32'hFFFF_FFFF);
    bus_read(NP*9, d);
    check("R1 unmapped read", {32'd0, d}, 64'd0);
    bus_read(255, d);
    check("R1 unmapped read top", {32'd0, d}, 64'd0);
    check_all_words("R1 unmapped write ignored");

    // R10: a single write leaves every other word untouched
    bus_write(9 + 5, 32'hDEAD_BEEF);
    check_all_words("R10 isolation");
    check_pads("R10 isolation");

    // R9: pad output updates one edge after the write edge
    bus_write(0, 32'h0000_0011);
    bus_write(4, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(4); bus_wdata = 32'h3;
    @(negedge clk);
    bus_wr = 1'b0; img[0][4] = 32'h3;
    check("R9 pad not yet updated", {62'd0, pad_out[1:0]}, 64'd0);
    @(negedge clk);
    check("R9 pad updated", {62'd0, pad_out[1:0]}, 64'd3);

    // R7: synchroniser latency on pin 4 of port 0 (function code 0)
    pad_in[4] = 1'b0;
    repeat (4) @(negedge clk);
    bus_addr = AW'(4); pad_in[4] = 1'b1;
    @(negedge clk);
    check("R7 edge1 old", {63'd0, bus_rdata[4]}, 64'd0);
    @(negedge clk);
    check("R7 edge2 old", {63'd0, bus_rdata[4]}, 64'd0);
    @(negedge clk);
    check("R7 edge3 new", {63'd0, bus_rdata[4]}, 64'd1);
    check("R6 latched bits on outputs", {62'd0, bus_rdata[1:0]}, 64'd3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [31:0] exp_oe0();
    logic [31:0] r;
    for (int p = 0; p < PN; p++)
      r[p] = (((img[0][p/8] >> (4*(p%8))) & 32'h7) == 1);
    return r;
  endfunction
endmodule